// File: doc/BRIEF.md
# SIMT Reconvergence Stack

This block keeps the divergence state of one warp whose scalar threads share a single instruction stream on a SIMD datapath. It holds a stack of entries. Each entry has a reconvergence PC, a next PC and an active mask with one bit per lane. The warp always runs the PC and the lane mask of the top entry, and both are driven straight onto `cur_pc` and `cur_mask`.

The branch unit reports a resolved branch with four values: the per-lane taken mask, the taken target, the fall-through target and the reconvergence PC. When the active lanes split, the block redirects the top entry to the reconvergence PC. It then pushes the taken path and, above it, the fall-through path, so the fall-through path runs first. When every active lane goes the same way, the block only moves the top entry's next PC. The fetch side reports ordinary progress with a PC-advance event.

When the next PC of the top entry arrives at that entry's reconvergence PC, the entry is removed and the entry below it resumes. The bottom entry covers the whole warp and has no reconvergence point.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the stack holds one entry: `depth` is 1, `cur_pc` equals the START_PC parameter, `cur_mask` is all ones and `overflow` is 0.
- R2: An advance event with no branch event sets `cur_pc` to `adv_pc` one cycle later and leaves `cur_mask` and `depth` unchanged, provided `adv_pc` is not the top entry's reconvergence PC.
- R3: A branch event whose active lanes all resolve one way is uniform. `cur_pc` becomes the taken target if any active lane is taken, and the fall-through target otherwise. `depth` and `cur_mask` do not change.
- R4: A branch event whose active lanes split is divergent. One cycle later `depth` has grown by 2, `cur_pc` is the fall-through target and `cur_mask` is the active mask with the taken lanes cleared.
- R5: When the top entry is above the bottom and an advance or uniform branch sets its next PC to its reconvergence PC, that entry is popped in the same cycle. `cur_pc` and `cur_mask` then come from the entry below. After the fall-through path pops, this is the taken target with the taken lanes.
- R6: After both paths of a divergent branch have popped, `cur_pc` is the reconvergence PC and `cur_mask` is the mask that was active before the branch.
- R7: When a branch event and an advance event arrive in the same cycle, the branch event is applied and the advance is ignored.
- R8: A divergent branch that finds fewer than two free entries leaves the stack unchanged and sets `overflow`. `overflow` stays 1 until reset.
- R9: In a cycle with no event, if the top entry sits above the bottom and its next PC already equals its reconvergence PC, that entry is popped. Only one level is popped per idle cycle.
- R10: The bottom entry is never popped. At `depth` 1, an advance to any PC, including 0, only updates `cur_pc`.
- R11: Bits of `br_taken` for lanes outside `cur_mask` are ignored when classifying and splitting a branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch-resolve event this cycle |
| br_taken | input | LANES | Per-lane taken outcome, bit i for lane i |
| br_target | input | PC_W | Taken target PC |
| br_fallthru | input | PC_W | Fall-through PC |
| br_reconv | input | PC_W | Reconvergence PC of the branch |
| adv_valid | input | 1 | PC-advance event this cycle |
| adv_pc | input | PC_W | Next PC for the advance event |
| cur_pc | output | PC_W | PC the warp executes (top entry's next PC) |
| cur_mask | output | LANES | Active lanes (top entry's mask) |
| depth | output | $clog2(DEPTH+1) | Number of valid entries |
| overflow | output | 1 | Sticky flag: a divergent push was refused |

## Verification
A corrupt stack pointer or entry shows up at the ports no later than the first pop that reaches it. It appears as a wrong `cur_mask`, a wrong `depth` or a reconvergence PC that is never honoured. A push that lands on the wrong slot surfaces only when the fall-through path completes, so the tests always walk both paths down to the reconvergence PC. Branch classification errors appear one cycle after the event, as a `depth` step of 2 where 0 was due or the reverse. The overflow and same-target cases exercise the guard paths that a plain walk never touches.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;
  typedef enum logic [2:0] {
    EV_NONE,
    EV_STEP,
    EV_SPLIT,
    EV_REFUSE,
    EV_POP
  } stack_ev_e;
endpackage

// File: rtl/simt_branch_split.sv
module simt_branch_split #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] active,
  input  logic [LANES-1:0] taken_req,
  output logic [LANES-1:0] taken_lanes,
  output logic [LANES-1:0] fall_lanes,
  output logic             diverged,
  output logic             any_taken
);
  function automatic logic [LANES-1:0] lanes_taken(input logic [LANES-1:0] act,
                                                   input logic [LANES-1:0] req);
    return act & req;
  endfunction

  function automatic logic [LANES-1:0] lanes_fall(input logic [LANES-1:0] act,
                                                  input logic [LANES-1:0] req);
    return act & ~req;
  endfunction

  always_comb begin
    taken_lanes = lanes_taken(active, taken_req);
    fall_lanes  = lanes_fall(active, taken_req);
    any_taken   = |taken_lanes;
    diverged    = any_taken && (|fall_lanes);
  end
endmodule

// File: rtl/simt_stack_store.sv
module simt_stack_store #(
  parameter int              LANES    = 4,
  parameter int              PC_W     = 16,
  parameter int              DEPTH    = 8,
  parameter logic [PC_W-1:0] START_PC = '0,
  localparam int             SP_W     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SP_W-1:0]  top_idx,
  input  logic             npc_we,
  input  logic [PC_W-1:0]  npc_val,
  input  logic             push_we,
  input  logic [PC_W-1:0]  push_rpc,
  input  logic [PC_W-1:0]  push_a_npc,
  input  logic [LANES-1:0] push_a_mask,
  input  logic [PC_W-1:0]  push_b_npc,
  input  logic [LANES-1:0] push_b_mask,
  output logic [PC_W-1:0]  top_npc,
  output logic [PC_W-1:0]  top_rpc,
  output logic [LANES-1:0] top_mask
);
  logic [PC_W-1:0]  rpc_q  [DEPTH];
  logic [PC_W-1:0]  npc_q  [DEPTH];
  logic [LANES-1:0] mask_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rpc_q[g]  <= '0;
        npc_q[g]  <= (g == 0) ? START_PC : '0;
        mask_q[g] <= (g == 0) ? '1 : '0;
      end else begin
        if (npc_we && int'(top_idx) == g)
          npc_q[g] <= npc_val;
        if (push_we && int'(top_idx) + 1 == g) begin
          rpc_q[g]  <= push_rpc;
          npc_q[g]  <= push_a_npc;
          mask_q[g] <= push_a_mask;
        end
        if (push_we && int'(top_idx) + 2 == g) begin
          rpc_q[g]  <= push_rpc;
          npc_q[g]  <= push_b_npc;
          mask_q[g] <= push_b_mask;
        end
      end
    end
  end

  assign top_npc  = npc_q[top_idx];
  assign top_rpc  = rpc_q[top_idx];
  assign top_mask = mask_q[top_idx];
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_stack_pkg::*;
#(
  parameter int              LANES    = 4,
  parameter int              PC_W     = 16,
  parameter int              DEPTH    = 8,
  parameter logic [PC_W-1:0] START_PC = 16'h0100,
  localparam int             SP_W     = $clog2(DEPTH),
  localparam int             DEPTH_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               br_valid,
  input  logic [LANES-1:0]   br_taken,
  input  logic [PC_W-1:0]    br_target,
  input  logic [PC_W-1:0]    br_fallthru,
  input  logic [PC_W-1:0]    br_reconv,
  input  logic               adv_valid,
  input  logic [PC_W-1:0]    adv_pc,
  output logic [PC_W-1:0]    cur_pc,
  output logic [LANES-1:0]   cur_mask,
  output logic [DEPTH_W-1:0] depth,
  output logic               overflow
);
  logic [SP_W-1:0]  sp_q, sp_d;
  logic             ovf_q, ovf_d;
  logic [PC_W-1:0]  top_npc, top_rpc;
  logic [LANES-1:0] top_mask;
  logic [LANES-1:0] taken_lanes, fall_lanes;
  logic             diverged, any_taken;
  logic             npc_we, push_we;
  logic [PC_W-1:0]  npc_val, step_pc;
  logic             has_parent, room2;
  stack_ev_e        ev;

  // Named event wires used by the assertions
  logic div_accept, div_reject, step_evt, evt_pop, idle_pop;

  simt_branch_split #(.LANES(LANES)) u_split (
    .active      (top_mask),
    .taken_req   (br_taken),
    .taken_lanes (taken_lanes),
    .fall_lanes  (fall_lanes),
    .diverged    (diverged),
    .any_taken   (any_taken)
  );

  simt_stack_store #(
    .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .START_PC(START_PC)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .top_idx     (sp_q),
    .npc_we      (npc_we),
    .npc_val     (npc_val),
    .push_we     (push_we),
    .push_rpc    (br_reconv),
    .push_a_npc  (br_target),
    .push_a_mask (taken_lanes),
    .push_b_npc  (br_fallthru),
    .push_b_mask (fall_lanes),
    .top_npc     (top_npc),
    .top_rpc     (top_rpc),
    .top_mask    (top_mask)
  );

  function automatic logic fits_two(input logic [SP_W-1:0] sp);
    return (int'(sp) + 2) <= (DEPTH - 1);
  endfunction

  assign has_parent = (sp_q != '0);
  assign room2      = fits_two(sp_q);
  assign step_pc    = br_valid ? (any_taken ? br_target : br_fallthru) : adv_pc;

  always_comb begin
    ev = EV_NONE;
    if (br_valid) begin
      if (diverged) ev = room2 ? EV_SPLIT : EV_REFUSE;
      else          ev = EV_STEP;
    end else if (adv_valid) begin
      ev = EV_STEP;
    end else if (has_parent && top_npc == top_rpc) begin
      ev = EV_POP;
    end
  end

  assign div_accept = (ev == EV_SPLIT);
  assign div_reject = (ev == EV_REFUSE);
  assign step_evt   = (ev == EV_STEP);
  assign evt_pop    = step_evt && has_parent && (step_pc == top_rpc);
  assign idle_pop   = (ev == EV_POP);

  always_comb begin
    sp_d    = sp_q;
    ovf_d   = ovf_q | div_reject;
    npc_we  = 1'b0;
    npc_val = step_pc;
    push_we = 1'b0;
    if (div_accept) begin
      npc_we  = 1'b1;
      npc_val = br_reconv;
      push_we = 1'b1;
      sp_d    = sp_q + SP_W'(2);
    end else if (evt_pop || idle_pop) begin
      sp_d = sp_q - SP_W'(1);
    end else if (step_evt) begin
      npc_we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      sp_q  <= sp_d;
      ovf_q <= ovf_d;
    end
  end

  assign cur_pc   = top_npc;
  assign cur_mask = top_mask;
  assign depth    = DEPTH_W'(sp_q) + DEPTH_W'(1);
  assign overflow = ovf_q;

  // R1: the bottom entry alone always covers every lane
  assert_bottom_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == DEPTH_W'(1)) |-> (cur_mask == '1));

  // R3: a uniform step that does not reach reconvergence keeps depth
  assert_uniform_depth_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !evt_pop) |=> (depth == $past(depth)));

  // R4: an accepted split grows the stack by two
  assert_split_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_accept |=> (depth == $past(depth) + DEPTH_W'(2)));

  // R4: the fall-through lanes run first
  assert_split_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_accept |=> (cur_mask == $past(fall_lanes)));

  // R5: reaching reconvergence drops exactly one level
  assert_event_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pop |=> (depth == $past(depth) - DEPTH_W'(1)));

  // R8: overflow is sticky and a refused split leaves depth alone
  assert_no_overflow_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_refuse_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_reject |=> (depth == $past(depth) && overflow));

  // R9: a deferred pop drops exactly one level
  assert_idle_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pop |=> (depth == $past(depth) - DEPTH_W'(1)));

  // R10: the bottom entry never goes away
  assert_bottom_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == DEPTH_W'(1) && !div_accept) |=> (depth == DEPTH_W'(1)));

  // R11: no active lane set ever empties
  assert_mask_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mask != '0);
endmodule

// File: tb/test_simt_reconv_stack.sv
`timescale 1ns/1ps
module test_simt_reconv_stack;
  localparam int LANES = 8;
  localparam int PC_W  = 16;
  localparam int DEPTH = 6;
  localparam int DW    = $clog2(DEPTH + 1);
  localparam logic [PC_W-1:0] START = 16'h0100;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             br_valid, adv_valid;
  logic [LANES-1:0] br_taken;
  logic [PC_W-1:0]  br_target, br_fallthru, br_reconv, adv_pc;
  logic [PC_W-1:0]  cur_pc;
  logic [LANES-1:0] cur_mask;
  logic [DW-1:0]    depth;
  logic             overflow;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  simt_reconv_stack #(
    .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .START_PC(START)
  ) i_simt_reconv_stack (
    .clk(clk), .rst_n(rst_n),
    .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
    .br_fallthru(br_fallthru), .br_reconv(br_reconv),
    .adv_valid(adv_valid), .adv_pc(adv_pc),
    .cur_pc(cur_pc), .cur_mask(cur_mask), .depth(depth), .overflow(overflow)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic look(input string tag, input logic [15:0] pc, input logic [7:0] m,
                      input int d, input logic ov);
    check({tag, " pc"}, 32'(cur_pc), 32'(pc));
    check({tag, " mask"}, 32'(cur_mask), 32'(m));
    check({tag, " depth"}, 32'(depth), 32'(d));
    check({tag, " overflow"}, 32'(overflow), 32'(ov));
  endtask

  task automatic clear_in();
    br_valid = 0; adv_valid = 0; br_taken = '0;
    br_target = '0; br_fallthru = '0; br_reconv = '0; adv_pc = '0;
  endtask

  task automatic do_reset();
    clear_in();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic branch(input logic [7:0] tk, input logic [15:0] tg, input logic [15:0] ft,
                        input logic [15:0] rc);
    br_valid = 1; br_taken = tk; br_target = tg; br_fallthru = ft; br_reconv = rc;
    @(negedge clk);
    clear_in();
  endtask

  task automatic advance(input logic [15:0] pc);
    adv_valid = 1; adv_pc = pc;
    @(negedge clk);
    clear_in();
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    look("R1 reset", START, 8'hff, 1, 0);
  endtask

  task automatic t_walk();
    do_reset();
    advance(16'h0104);
    look("R2 advance", 16'h0104, 8'hff, 1, 0);
    branch(8'h0f, 16'h0200, 16'h0180, 16'h0300);
    look("R4 split", 16'h0180, 8'hf0, 3, 0);
    advance(16'h0184);
    look("R2 advance in path", 16'h0184, 8'hf0, 3, 0);
    advance(16'h0300);
    look("R5 fall path pop", 16'h0200, 8'h0f, 2, 0);
    advance(16'h0300);
    look("R6 reconverged", 16'h0300, 8'hff, 1, 0);
  endtask

  task automatic t_uniform();
    do_reset();
    branch(8'hff, 16'h0220, 16'h0204, 16'h0400);
    look("R3 all taken", 16'h0220, 8'hff, 1, 0);
    branch(8'h00, 16'h0230, 16'h0224, 16'h0400);
    look("R3 none taken", 16'h0224, 8'hff, 1, 0);
  endtask

  task automatic t_mask_filter();
    do_reset();
    branch(8'h0f, 16'h0200, 16'h0180, 16'h0900);
    branch(8'h0f, 16'h0260, 16'h0264, 16'h0900);
    look("R11 inactive taken bits", 16'h0264, 8'hf0, 3, 0);
    branch(8'hf3, 16'h0268, 16'h026c, 16'h0900);
    look("R11 active all taken", 16'h0268, 8'hf0, 3, 0);
  endtask

  task automatic t_priority();
    do_reset();
    br_valid = 1; br_taken = 8'hff; br_target = 16'h0240;
    br_fallthru = 16'h0244; br_reconv = 16'h0800;
    adv_valid = 1; adv_pc = 16'h0500;
    @(negedge clk);
    clear_in();
    look("R7 branch wins", 16'h0240, 8'hff, 1, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    branch(8'h0f, 16'h0200, 16'h0180, 16'h0700);
    branch(8'h30, 16'h0210, 16'h0190, 16'h0600);
    look("R4 nested split", 16'h0190, 8'hc0, 5, 0);
    branch(8'h40, 16'h0220, 16'h01a0, 16'h0500);
    look("R8 refused split", 16'h0190, 8'hc0, 5, 1);
    advance(16'h0194);
    idle();
    look("R8 overflow sticky", 16'h0194, 8'hc0, 5, 1);
  endtask

  task automatic t_deferred();
    do_reset();
    branch(8'h0f, 16'h0300, 16'h0180, 16'h0300);
    look("R4 split target at reconv", 16'h0180, 8'hf0, 3, 0);
    advance(16'h0300);
    look("R5 pop to taken entry", 16'h0300, 8'h0f, 2, 0);
    idle();
    look("R9 deferred pop", 16'h0300, 8'hff, 1, 0);
    idle();
    look("R9 stays at bottom", 16'h0300, 8'hff, 1, 0);
  endtask

  task automatic t_bottom();
    do_reset();
    advance(16'h0000);
    look("R10 bottom kept", 16'h0000, 8'hff, 1, 0);
    idle();
    look("R10 bottom idle", 16'h0000, 8'hff, 1, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    clear_in();
    rst_n = 0;
    t_reset();
    t_walk();
    t_uniform();
    t_mask_filter();
    t_priority();
    t_overflow();
    t_deferred();
    t_bottom();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule